// File: doc/BRIEF.md
# Multi-level priority bus arbiter

This block is a central arbitration unit for a bus shared by several priority levels. Each level has one request input and one grant output. The grant output starts a daisy chain that runs through the devices at that level. The device that keeps the grant raises a shared acknowledge line, and that line stays high for as long as the device holds the bus.

The arbiter looks at the request lines only while the acknowledge line is low and no grant is outstanding. At those times it copies the request lines into a holding register. Once the acknowledge line has been low for a set number of clock cycles, the arbiter raises the grant for the highest-numbered request it holds. It then closes the holding register. From that point, a request that arrives late, even from a higher level, cannot start a second grant down another chain. The grant drops when the acknowledge line rises. The holding register opens again only after the acknowledge line falls once more.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every grant output is low.
- R2: At most one grant output is high in any cycle.
- R3: The grant that is raised is the one at the highest bit index among the held requests. Bit j of the request vector pairs with bit j of the grant vector, and a higher index means a higher priority.
- R4: Counted from the first clock edge at which the acknowledge line is sampled low, no grant becomes visible earlier than SETTLE+1 edges. SETTLE defaults to 2.
- R5: Once a grant is high, it stays unchanged until the acknowledge line rises, whatever the request lines do in the meantime.
- R6: One edge after the acknowledge line is sampled high, all grants are low. They stay low for as long as the acknowledge line stays high.
- R7: If no request is held, no grant is raised. While the acknowledge line stays low and has settled, the arbiter samples again on every edge. A request that appears then is granted two edges later.
- R8: After the acknowledge line falls, the holding register takes in fresh requests, and a new arbitration round follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | LEVELS | One request line per priority level |
| slave_ack | input | 1 | Shared acknowledge from the current winner |
| bus_grant | output | LEVELS | One-hot grant, one line per level |

## Verification
The assertions assume that the acknowledge line rises only after a grant, and that the request lines are already stable at the clock edge, that is, they have been synchronised upstream. The settle check counts low acknowledge cycles from reset, so it assumes reset is released with the acknowledge line in a known state. The stimulus changes every input on the falling clock edge. It raises the acknowledge line only after a grant, or while the arbiter is idle in the sweep setup. That keeps each arbitration round clean for the assertions.

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int LEVELS = 4,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] bus_req,
  input  logic              slave_ack,
  output logic [LEVELS-1:0] bus_grant
);
  localparam int CW = $clog2(SETTLE + 1) + 1;

  logic [LEVELS-1:0] held;
  logic [LEVELS-1:0] grant_q;
  logic [CW-1:0]     quiet;

  function automatic logic [LEVELS-1:0] top_bit(input logic [LEVELS-1:0] v);
    logic [LEVELS-1:0] r;
    r = '0;
    for (int i = 0; i < LEVELS; i++)
      if (v[i]) r = LEVELS'(1) << i;
    return r;
  endfunction

  wire settled = (quiet == CW'(SETTLE));
  wire idle    = !slave_ack && (grant_q == '0);
  wire fire    = idle && settled && (held != '0);
  wire open_w  = idle && !fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet   <= '0;
      held    <= '0;
      grant_q <= '0;
    end else begin
      if (slave_ack)     quiet <= '0;
      else if (!settled) quiet <= quiet + 1'b1;

      if (open_w) held <= bus_req;

      if (slave_ack) grant_q <= '0;
      else if (fire) grant_q <= top_bit(held);
    end
  end

  assign bus_grant = grant_q;
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int LEVELS = 4,
  parameter int SETTLE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEVELS-1:0] bus_req,
  input logic              slave_ack,
  input logic [LEVELS-1:0] bus_grant
);
  localparam int RW = $clog2(SETTLE + 2) + 1;
  logic [RW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (slave_ack) low_run <= '0;
    else if (low_run != RW'(SETTLE + 1)) low_run <= low_run + 1'b1;
  end

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant));

  assert_drop_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slave_ack |=> (bus_grant == '0));

  assert_hold_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_ack && bus_grant != '0) |=> (bus_grant == $past(bus_grant)));

  assert_settle_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|bus_grant) |-> (low_run == RW'(SETTLE + 1)));

  assert_granted_level_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|bus_grant) |-> ((bus_grant & $past(bus_req, 2)) != '0));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.LEVELS(LEVELS), .SETTLE(SETTLE)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .slave_ack(slave_ack), .bus_grant(bus_grant)
);

// File: tb/prio_bus_arbiter_test.sv
module prio_bus_arbiter_test;
  localparam int LEVELS = 4;
  localparam int SETTLE = 2;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [LEVELS-1:0] bus_req = '0;
  logic              slave_ack = 1'b1;
  logic [LEVELS-1:0] bus_grant;
  int checks = 0;
  int fails = 0;

  prio_bus_arbiter #(.LEVELS(LEVELS), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .slave_ack(slave_ack), .bus_grant(bus_grant)
  );

  always #10 clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [LEVELS-1:0] exp);
    checks++;
    if (bus_grant !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b", req, bus_grant, exp);
    end
  endtask

  function automatic logic [LEVELS-1:0] expect_top(input int v);
    int b;
    b = -1;
    for (int i = 0; i < LEVELS; i++) if ((v >> i) & 1) b = i;
    return (b < 0) ? '0 : LEVELS'(1 << b);
  endfunction

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: grant=%b expected=done", bus_grant);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    check("R1 in reset", '0);
    rst_n = 1;
    step(1);
    check("R1 after reset", '0);

    for (int pat = 0; pat < (1 << LEVELS); pat++) begin
      bus_req = LEVELS'(pat);
      slave_ack = 0;
      step(SETTLE);
      check("R4 before settle", '0);
      step(1);
      check("R3/R2/R8 winner", expect_top(pat));
      bus_req = '1;
      if (pat == 0) begin
        step(1);
        check("R7 resample pending", '0);
        step(1);
        check("R7 resample grant", expect_top((1 << LEVELS) - 1));
      end else begin
        step(3);
        check("R5 late request ignored", expect_top(pat));
      end
      slave_ack = 1;
      step(1);
      check("R6 drop on ack", '0);
      bus_req = LEVELS'(pat);
      step(3);
      check("R6 low while ack", '0);
    end

    slave_ack = 0;
    bus_req = '0;
    step(SETTLE + 4);
    check("R7 no request", '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule